// File: doc/BRIEF.md
# Chip-Select Pulse Clock Calibrator

This block sets the time base of a PWM channel from a timed pulse instead of a register value. Software first arms the block. It then drives the chip-select line low for a chosen length of time. The block counts that low time in cycles of a fast reference clock. When the count falls inside an allowed window, the count divided by a fixed prescale constant becomes the divisor of the internal PWM clock. A count outside the window is discarded, and the divisor keeps its previous value. Until the first accepted pulse, the divisor keeps its default value.

The block emits a single-cycle tick for every period of the divided clock. It also emits a period strobe on every `PERIOD_TICKS`-th tick, so one switching period lasts 256 internal clock periods with the default setting. A new divisor takes effect only at a period boundary, so no switching period is cut short. While the run enable is low, the divider and period counters are held at zero. Two copies of the block that share a reference clock, use equal divisors and are enabled in the same cycle therefore stay aligned.

Top module: `cs_pulse_clk_cal`

## Requirements
- R1: After reset, `calibrated` and `cal_valid` are 0, and the divisor is `DEF_DIV` (8 by default).
- R2: While `run_en` is 1, `clk_tick` is high for one cycle out of every divisor cycles. `period_strobe` is high together with every `PERIOD_TICKS`-th tick and at no other time.
- R3: While `run_en` is 0, `clk_tick` and `period_strobe` stay low and both counters are held at zero. The first tick comes divisor−1 cycles after the cycle in which `run_en` rises, and the first strobe comes `PERIOD_TICKS`×divisor−1 cycles after that cycle.
- R4: `cs_n` passes through two synchronising flip-flops. A low pulse is measured only if `cal_arm` was pulsed high before the pulse's falling edge. One arm covers exactly one pulse, and pulses without an arm have no effect.
- R5: A measured pulse of L reference cycles, with `MIN_CNT` ≤ L ≤ `MAX_CNT` (16 and 64 by default), is accepted. `cal_valid` then pulses high for exactly one cycle, three cycles after `cs_n` returns high.
- R6: A measured pulse with L < `MIN_CNT` or L > `MAX_CNT` is discarded. It produces no `cal_valid` pulse and leaves the divisor unchanged. The length counter saturates at `MAX_CNT`+1, so a pulse of any length is rejected.
- R7: An accepted pulse sets the divisor to floor(L / `PRESCALE`), with `PRESCALE` = 4 by default. The new value is applied at the next period strobe, or at once while `run_en` is 0. A later accepted pulse that arrives before the change is applied replaces the pending value.
- R8: `calibrated` goes high with the first `cal_valid` pulse and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| run_en | input | 1 | Runs the divider and period counters; low holds them at zero |
| cal_arm | input | 1 | Arms measurement of the next chip-select low pulse |
| cs_n | input | 1 | Chip-select line whose low time is measured; asynchronous |
| clk_tick | output | 1 | One-cycle tick per period of the calibrated clock |
| period_strobe | output | 1 | One-cycle strobe at the end of each switching period |
| cal_valid | output | 1 | One-cycle pulse when a pulse is accepted |
| calibrated | output | 1 | Sticky flag: at least one pulse has been accepted |

## Verification
Some properties are checked on every cycle:
- `cal_valid` never lasts two cycles.
- `calibrated` never falls and is high whenever `cal_valid` is.
- A strobe always coincides with a tick.
- Ticks and strobes stay quiet while the block is disabled.
- The divisor changes only at a strobe or while the block is disabled.

Other behaviour can only be shown by the bench's scenarios:
- Which pulse lengths are accepted, and at which edges of the window.
- The exact cycle of the `cal_valid` pulse.
- The arithmetic of the divisor.
- That one arm covers only one pulse.
- The tick and strobe spacing before and after a boundary.
- The first-tick offset after enable, which is what keeps two channels aligned.

// File: rtl/cs_pulse_clk_cal.sv
module cs_pulse_clk_cal #(
  parameter int MIN_CNT      = 16,
  parameter int MAX_CNT      = 64,
  parameter int PRESCALE     = 4,
  parameter int DEF_DIV      = 8,
  parameter int PERIOD_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic cal_arm,
  input  logic cs_n,
  output logic clk_tick,
  output logic period_strobe,
  output logic cal_valid,
  output logic calibrated
);
  localparam int CW   = $clog2(MAX_CNT + 2);
  localparam int DMAX = (MAX_CNT / PRESCALE > DEF_DIV) ? MAX_CNT / PRESCALE : DEF_DIV;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int PW   = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;

  logic          cs_s1, cs_s2, cs_d;
  logic          armed, meas_on;
  logic [CW-1:0] meas_cnt;
  logic [DW-1:0] div_q, pend_div, div_cnt;
  logic          pend;
  logic [PW-1:0] tick_cnt;

  wire cs_fall = cs_d & ~cs_s2;
  wire cs_rise = ~cs_d & cs_s2;
  wire in_win  = (meas_cnt >= CW'(MIN_CNT)) && (meas_cnt <= CW'(MAX_CNT));
  wire accept  = meas_on & cs_rise & in_win;

  assign clk_tick      = run_en && (div_cnt == div_q - DW'(1));
  assign period_strobe = clk_tick && (tick_cnt == PW'(PERIOD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_s1 <= 1'b1;
      cs_s2 <= 1'b1;
      cs_d  <= 1'b1;
    end else begin
      cs_s1 <= cs_n;
      cs_s2 <= cs_s1;
      cs_d  <= cs_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      meas_on  <= 1'b0;
      meas_cnt <= '0;
    end else begin
      if (cs_fall && armed) begin
        armed    <= 1'b0;
        meas_on  <= 1'b1;
        meas_cnt <= CW'(1);
      end else begin
        if (cal_arm) armed <= 1'b1;
        if (meas_on) begin
          if (cs_rise)                            meas_on  <= 1'b0;
          else if (meas_cnt != CW'(MAX_CNT + 1))  meas_cnt <= meas_cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_valid  <= 1'b0;
      calibrated <= 1'b0;
      pend       <= 1'b0;
      pend_div   <= DW'(DEF_DIV);
      div_q      <= DW'(DEF_DIV);
    end else begin
      cal_valid <= accept;
      if (accept) begin
        calibrated <= 1'b1;
        pend       <= 1'b1;
        pend_div   <= DW'(meas_cnt / CW'(PRESCALE));
      end else if (pend && (period_strobe || !run_en)) begin
        pend  <= 1'b0;
        div_q <= pend_div;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (clk_tick) begin
      div_cnt  <= '0;
      tick_cnt <= period_strobe ? '0 : tick_cnt + PW'(1);
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end
endmodule

// File: rtl/cs_pulse_clk_cal_chk.sv
module cs_pulse_clk_cal_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          clk_tick,
  input logic          period_strobe,
  input logic          cal_valid,
  input logic          calibrated,
  input logic [DW-1:0] div_q
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |=> !cal_valid); // R5
  AST_CAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated |=> calibrated); // R8
  AST_VALID_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |-> calibrated); // R8
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |-> clk_tick); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!clk_tick && !period_strobe)); // R3
  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> $past(period_strobe || !run_en)); // R7
endmodule

bind cs_pulse_clk_cal cs_pulse_clk_cal_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_tick(clk_tick),
  .period_strobe(period_strobe), .cal_valid(cal_valid),
  .calibrated(calibrated), .div_q(div_q)
);

// File: tb/cs_pulse_clk_cal_bench.sv
module cs_pulse_clk_cal_bench;
  localparam int MINC = 16, MAXC = 64, PRE = 4, DEFD = 8, PT = 256;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, cal_arm = 1'b0, cs_n = 1'b1;
  logic clk_tick, period_strobe, cal_valid, calibrated;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cs_pulse_clk_cal #(.MIN_CNT(MINC), .MAX_CNT(MAXC), .PRESCALE(PRE),
                     .DEF_DIV(DEFD), .PERIOD_TICKS(PT)) u_cs_pulse_clk_cal (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cal_arm(cal_arm), .cs_n(cs_n),
    .clk_tick(clk_tick), .period_strobe(period_strobe),
    .cal_valid(cal_valid), .calibrated(calibrated));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk); cal_arm = 1'b1;
    @(negedge clk); cal_arm = 1'b0;
  endtask

  task automatic pulse(input int n, output int nvalid, output int pos);
    nvalid = 0; pos = -1;
    @(negedge clk); cs_n = 1'b0;
    repeat (n) @(negedge clk);
    cs_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      if (cal_valid) begin nvalid++; if (pos < 0) pos = k; end
      @(negedge clk);
    end
  endtask

  task automatic enable_first(output int ft, output int fs);
    ft = -1; fs = -1;
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); run_en = 1'b1;
    for (int k = 0; k < 5000 && fs < 0; k++) begin
      #1;
      if (clk_tick && ft < 0) ft = k;
      if (period_strobe) fs = k;
      @(negedge clk);
    end
  endtask

  task automatic tick_gap(output int gap);
    int k = 0;
    while (!clk_tick) @(negedge clk);
    @(negedge clk); k = 1;
    while (!clk_tick && k < 100) begin @(negedge clk); k++; end
    gap = k;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ft, fs, nv, pos, gap, last_tick, kk, gap_at_strobe, gap_after;
    repeat (4) @(negedge clk);
    #1;
    check("R1 calibrated after reset", calibrated, 0);
    check("R1 cal_valid after reset", cal_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R3 tick while disabled", clk_tick, 0);

    enable_first(ft, fs);
    check("R1 R3 first tick default divisor", ft, DEFD - 1);
    check("R2 R3 first strobe", fs, PT * DEFD - 1);
    tick_gap(gap);
    check("R2 tick spacing", gap, DEFD);

    arm();
    pulse(MINC - 1, nv, pos);
    check("R6 below min rejected", nv, 0);
    arm();
    pulse(200, nv, pos);
    check("R6 saturated long pulse rejected", nv, 0);
    pulse(40, nv, pos);
    check("R4 unarmed pulse ignored", nv, 0);
    check("R8 still uncalibrated", calibrated, 0);
    tick_gap(gap);
    check("R6 divisor unchanged", gap, DEFD);

    arm();
    pulse(48, nv, pos);
    check("R5 accepted count", nv, 1);
    check("R5 cal_valid position", pos, 3);
    check("R8 calibrated set", calibrated, 1);
    pulse(20, nv, pos);
    check("R4 arm covers one pulse", nv, 0);

    last_tick = -1; kk = 0; gap_at_strobe = -1;
    while (gap_at_strobe < 0 && kk < 5000) begin
      #1;
      if (clk_tick) begin
        if (period_strobe) gap_at_strobe = kk - last_tick;
        last_tick = kk;
      end
      @(negedge clk); kk++;
    end
    check("R7 old divisor up to boundary", gap_at_strobe, DEFD);
    kk = 1;
    while (kk < 100) begin #1; if (clk_tick) break; @(negedge clk); kk++; end
    gap_after = kk;
    check("R7 new divisor after boundary", gap_after, 48 / PRE);

    @(negedge clk); run_en = 1'b0;
    for (int n = MINC - 6; n <= MAXC + 6; n++) begin
      arm();
      pulse(n, nv, pos);
      check($sformatf("R5 R6 window sweep L=%0d", n), nv, (n >= MINC && n <= MAXC) ? 1 : 0);
    end
    check("R8 sticky after rejects", calibrated, 1);
    enable_first(ft, fs);
    check("R7 R3 first tick after sweep", ft, MAXC / PRE - 1);
    check("R2 R3 strobe after sweep", fs, PT * (MAXC / PRE) - 1);

    @(negedge clk); run_en = 1'b0;
    arm(); pulse(MINC, nv, pos);
    arm(); pulse(37, nv, pos);
    enable_first(ft, fs);
    check("R7 latest pending value wins", ft, 37 / PRE - 1);

    @(negedge clk); run_en = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 R8 calibrated cleared by reset", calibrated, 0);
    enable_first(ft, fs);
    check("R1 default divisor after reset", ft, DEFD - 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule